// File: doc/BRIEF.md
# Expected Checksum Table with Recency-Ordered Refill

This block is a small, fully associative store of expected checksums for straight-line code regions. Each entry records the first address of a region, its last address and the checksum the region should produce. A monitor presents a finished region as a start address, an end address and the checksum it computed. The table then reports two results. The first says whether that exact address range is stored. The second says whether the stored checksum also equals the one presented. A range that is absent and a checksum that differs are different faults, and the monitor treats them in different ways.

When a lookup misses, the owner of the table starts a refill and streams in records, one per cycle. The table overwrites half of its entries. Empty entries are used first, then the least recently used ones. A controller with two states governs this. In `ST_IDLE`, lookups are served. The transition `go_refill` is taken when `refill_go` is seen in `ST_IDLE`. In `ST_REFILL`, one record is written per strobe. The transition `refill_complete` returns to `ST_IDLE` on the last write of the batch.

Top module: `exp_hash_table`

## Requirements
- R1: After reset every entry is empty, the state is `ST_IDLE`, and all outputs are 0. The first lookup therefore returns found=0 and match=0.
- R2: A lookup accepted in `ST_IDLE` (`lk_req`=1) gives `lk_valid`=1 on the following cycle, together with its found and match results. `lk_valid` is 1 in no other case.
- R3: Found is 1 only when a valid entry holds both the presented start address and the presented end address. An entry whose start address agrees but whose end address differs does not count.
- R4: Match is 1 only when found is 1 and the checksum stored in the hit entry equals `lk_hash`. When the range is present but the checksum differs, the result is found=1, match=0.
- R5: `refill_go` in `ST_IDLE` moves the controller to `ST_REFILL` on the next cycle, and `fill_busy` is 1 while in that state. A lookup presented during `ST_REFILL` is dropped and produces no `lk_valid`.
- R6: In `ST_REFILL`, each cycle with `fill_vld`=1 writes one record. The batch is DEPTH/2 writes, or one write when DEPTH is 1. On the cycle after the last write, `fill_done` is 1 for one cycle, `fill_busy` is 0, and the written records are found on lookup.
- R7: A refill writes empty entries before it replaces any valid entry.
- R8: Once all entries are valid, each refill write replaces the least recently used entry. Any lookup that finds its range (whether or not the checksum matches) makes that entry most recently used. A freshly written entry is also most recently used.
- R9: `fill_vld` in `ST_IDLE` writes nothing: a record presented that way is not found afterwards.
- R10: A lookup that does not find its range leaves the recency order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_start | input | ADDR_W | Region start address to look up |
| lk_end | input | ADDR_W | Region end address to look up |
| lk_hash | input | HASH_W | Checksum computed for the region |
| lk_valid | output | 1 | Lookup result valid (one cycle after request) |
| lk_found | output | 1 | Address range present |
| lk_match | output | 1 | Range present and checksum equal |
| refill_go | input | 1 | Start a refill batch |
| fill_vld | input | 1 | Refill record strobe |
| fill_start | input | ADDR_W | Refill record start address |
| fill_end | input | ADDR_W | Refill record end address |
| fill_hash | input | HASH_W | Refill record expected checksum |
| fill_busy | output | 1 | Controller is in `ST_REFILL` |
| fill_done | output | 1 | One-cycle pulse after the last write of a batch |

## Verification
The hardest situation to reach is a refill into a full table where the recency order is no longer the insertion order. In that case the victims show whether hits really refresh an entry and whether misses really leave it alone. The stimulus first fills all entries in two batches. It then touches older entries with hits, including one hit with a bad checksum. It adds a miss and an ignored idle write, and starts a third batch. Lookups afterwards show which records survived. This outcome is compared against a behavioural recency list.

// File: rtl/ht_pkg.sv
package ht_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REFILL = 1'b1
    } ht_state_e;
endpackage

// File: rtl/ht_cam.sv
module ht_cam #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int HASH_W = 32,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_start,
    input  logic [ADDR_W-1:0] wr_end,
    input  logic [HASH_W-1:0] wr_hash,
    input  logic [ADDR_W-1:0] q_start,
    input  logic [ADDR_W-1:0] q_end,
    input  logic [HASH_W-1:0] q_hash,
    output logic [DEPTH-1:0]  hit_vec,
    output logic [DEPTH-1:0]  heq_vec,
    output logic [DEPTH-1:0]  vld_vec
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [ADDR_W-1:0] st_q, en_q;
        logic [HASH_W-1:0] hs_q;
        logic              v_q;
        logic              sel;

        assign sel = wr_en && (wr_idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
            end else if (sel) begin
                v_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                st_q <= wr_start;
                en_q <= wr_end;
                hs_q <= wr_hash;
            end
        end

        assign vld_vec[i] = v_q;
        assign hit_vec[i] = v_q && (st_q == q_start) && (en_q == q_end);
        assign heq_vec[i] = (hs_q == q_hash);
    end
endmodule

// File: rtl/ht_lru.sv
module ht_lru #(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [DEPTH-1:0] vld_vec,
    output logic [IDX_W-1:0] victim_idx
);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] age_q [DEPTH];
    logic [IDX_W-1:0] ref_age;

    assign ref_age = age_q[touch_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) age_q[i] <= IDX_W'(i);
        end else if (touch_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (IDX_W'(i) == touch_idx)  age_q[i] <= '0;
                else if (age_q[i] < ref_age) age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    always_comb begin
        logic have_empty;
        victim_idx = '0;
        have_empty = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (age_q[i] == OLDEST) victim_idx = IDX_W'(i);
        end
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_vec[i]) begin
                victim_idx = IDX_W'(i);
                have_empty = 1'b1;
            end
        end
    end
endmodule

// File: rtl/exp_hash_table.sv
module exp_hash_table #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int HASH_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_start,
    input  logic [ADDR_W-1:0] lk_end,
    input  logic [HASH_W-1:0] lk_hash,
    output logic              lk_valid,
    output logic              lk_found,
    output logic              lk_match,
    input  logic              refill_go,
    input  logic              fill_vld,
    input  logic [ADDR_W-1:0] fill_start,
    input  logic [ADDR_W-1:0] fill_end,
    input  logic [HASH_W-1:0] fill_hash,
    output logic              fill_busy,
    output logic              fill_done
);
    import ht_pkg::*;

    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int FILL_N = (DEPTH > 1) ? DEPTH / 2 : 1;
    localparam int CNT_W  = $clog2(FILL_N + 1);

    ht_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [DEPTH-1:0] hit_vec, heq_vec, vld_vec;
    logic [IDX_W-1:0] hit_idx, victim_idx, touch_idx;
    logic             found_c, lk_take, wr_en, last_wr, touch_en;

    assign lk_take   = (state_q == ST_IDLE) && lk_req;
    assign wr_en     = (state_q == ST_REFILL) && fill_vld;
    assign last_wr   = wr_en && (cnt_q == CNT_W'(FILL_N - 1));
    assign found_c   = |hit_vec;
    assign touch_en  = wr_en || (lk_take && found_c);
    assign touch_idx = wr_en ? victim_idx : hit_idx;
    assign fill_busy = (state_q == ST_REFILL);

    always_comb begin
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: go_refill, refill_complete
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (refill_go) state_d = ST_REFILL;
            ST_REFILL: if (last_wr)   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (state_q == ST_IDLE)    cnt_q <= '0;
        else if (wr_en)                 cnt_q <= cnt_q + 1'b1;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_valid  <= 1'b0;
            lk_found  <= 1'b0;
            lk_match  <= 1'b0;
            fill_done <= 1'b0;
        end else begin
            lk_valid  <= lk_take;
            lk_found  <= lk_take && found_c;
            lk_match  <= lk_take && found_c && heq_vec[hit_idx];
            fill_done <= last_wr;
        end
    end

    ht_cam #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .HASH_W(HASH_W)) u_cam (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(victim_idx),
        .wr_start(fill_start), .wr_end(fill_end), .wr_hash(fill_hash),
        .q_start(lk_start), .q_end(lk_end), .q_hash(lk_hash),
        .hit_vec(hit_vec), .heq_vec(heq_vec), .vld_vec(vld_vec)
    );

    ht_lru #(.DEPTH(DEPTH)) u_lru (
        .clk(clk), .rst_n(rst_n),
        .touch_en(touch_en), .touch_idx(touch_idx),
        .vld_vec(vld_vec), .victim_idx(victim_idx)
    );
endmodule

// File: rtl/ht_checker.sv
module ht_checker #(
    parameter int DEPTH = 8
) (
    input logic clk,
    input logic rst_n,
    input logic lk_req,
    input logic lk_valid,
    input logic lk_found,
    input logic lk_match,
    input logic refill_go,
    input logic fill_vld,
    input logic fill_busy,
    input logic fill_done
);
    localparam int FILL_N = (DEPTH > 1) ? DEPTH / 2 : 1;
    localparam int CNT_W  = $clog2(FILL_N + 2);

    logic [CNT_W-1:0] wcnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    wcnt <= '0;
        else if (fill_busy && fill_vld) wcnt <= wcnt + 1'b1;
        else if (!fill_busy)           wcnt <= '0;
    end

    // R2
    resp_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $past(lk_req && !fill_busy));
    // R2
    req_gets_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !fill_busy) |=> lk_valid);
    // R2
    found_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_found |-> lk_valid);
    // R4
    match_needs_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_match |-> lk_found);
    // R5
    enter_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_busy && refill_go) |=> fill_busy);
    // R6
    done_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> (!fill_busy && $past(fill_busy)));
    // R6
    batch_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> (wcnt == CNT_W'(FILL_N)));
endmodule

bind exp_hash_table ht_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_valid(lk_valid),
    .lk_found(lk_found), .lk_match(lk_match), .refill_go(refill_go),
    .fill_vld(fill_vld), .fill_busy(fill_busy), .fill_done(fill_done)
);

// File: tb/sim_exp_hash_table.sv
`timescale 1ns/1ps
module sim_exp_hash_table;
    localparam int DEPTH = 8;
    localparam int AW = 32;
    localparam int HW = 32;
    localparam int FILL_N = DEPTH / 2;

    typedef struct {
        logic [AW-1:0] s;
        logic [AW-1:0] e;
        logic [HW-1:0] h;
    } rec_t;

    logic clk = 0, rst_n = 0;
    logic lk_req = 0, refill_go = 0, fill_vld = 0;
    logic [AW-1:0] lk_start = 0, lk_end = 0, fill_start = 0, fill_end = 0;
    logic [HW-1:0] lk_hash = 0, fill_hash = 0;
    logic lk_valid, lk_found, lk_match, fill_busy, fill_done;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    rec_t mq[$];       // recency list, index 0 = most recent
    bit   m_busy = 0;
    int   m_cnt = 0;

    always #2.5 clk = ~clk;

    exp_hash_table #(.DEPTH(DEPTH), .ADDR_W(AW), .HASH_W(HW)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_start(lk_start),
        .lk_end(lk_end), .lk_hash(lk_hash), .lk_valid(lk_valid),
        .lk_found(lk_found), .lk_match(lk_match), .refill_go(refill_go),
        .fill_vld(fill_vld), .fill_start(fill_start), .fill_end(fill_end),
        .fill_hash(fill_hash), .fill_busy(fill_busy), .fill_done(fill_done)
    );

    function automatic rec_t mk(int i);
        rec_t r;
        r.s = AW'(i * 256);
        r.e = AW'(i * 256 + 16);
        r.h = HW'(i) * 32'h9E3779B1 + 32'h1234;
        return r;
    endfunction

    task automatic chk(bit act, bit exp, string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // one clock: model steps on sampled inputs, outputs compared after edge
    task automatic cycle();
        bit ev = 0, ef = 0, em = 0, ed = 0;
        @(posedge clk);
        if (rst_n) begin
            if (!m_busy) begin
                if (lk_req) begin
                    ev = 1;
                    foreach (mq[k]) begin
                        if (!ef && mq[k].s == lk_start && mq[k].e == lk_end) begin
                            rec_t t = mq[k];
                            ef = 1;
                            em = (t.h == lk_hash);
                            mq.delete(k);
                            mq.push_front(t);
                            break;
                        end
                    end
                end
                if (refill_go) begin
                    m_busy = 1;
                    m_cnt = 0;
                end
            end else if (fill_vld) begin
                rec_t r;
                r.s = fill_start; r.e = fill_end; r.h = fill_hash;
                if (mq.size() == DEPTH) void'(mq.pop_back());
                mq.push_front(r);
                m_cnt++;
                if (m_cnt == FILL_N) begin
                    m_busy = 0;
                    ed = 1;
                end
            end
        end
        #1;
        chk(lk_valid, ev, "R2/R5 lk_valid");
        chk(lk_found, ef, "R3 lk_found");
        chk(lk_match, em, "R4 lk_match");
        chk(fill_busy, m_busy, "R5 fill_busy");
        chk(fill_done, ed, "R6 fill_done");
    endtask

    task automatic lookup(rec_t r);
        lk_req = 1; lk_start = r.s; lk_end = r.e; lk_hash = r.h;
        cycle();
        lk_req = 0;
    endtask

    task automatic expect_lookup(rec_t r, bit f, bit m, string tag);
        lookup(r);
        chk(lk_found, f, {tag, " found"});
        chk(lk_match, m, {tag, " match"});
    endtask

    task automatic refill(int first);
        refill_go = 1;
        cycle();
        refill_go = 0;
        for (int i = 0; i < FILL_N; i++) begin
            rec_t r = mk(first + i);
            fill_vld = 1; fill_start = r.s; fill_end = r.e; fill_hash = r.h;
            cycle();
        end
        fill_vld = 0;
        chk(fill_done, 1'b1, "R6 done pulse");
        cycle();
        chk(fill_done, 1'b0, "R6 done single");
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rec_t r;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(lk_valid, 0, "R1 reset lk_valid");
        chk(fill_busy, 0, "R1 reset fill_busy");
        chk(fill_done, 0, "R1 reset fill_done");
        rst_n = 1;
        cycle();
        expect_lookup(mk(0), 0, 0, "R1 empty table");

        refill(0);
        for (int i = 0; i < 4; i++) expect_lookup(mk(i), 1, 1, "R6 written records");
        refill(4);
        // R7 empty slots used before valid ones
        for (int i = 0; i < 4; i++) expect_lookup(mk(i), 1, 1, "R7 first batch kept");

        // R9 idle write ignored
        r = mk(8);
        fill_vld = 1; fill_start = r.s; fill_end = r.e; fill_hash = r.h;
        cycle();
        fill_vld = 0;
        expect_lookup(mk(8), 0, 0, "R9 idle write");  // also R10 miss

        r = mk(5); r.e = r.e + 4;
        expect_lookup(r, 0, 0, "R3 end differs");
        r = mk(6); r.h = ~r.h;
        expect_lookup(r, 1, 0, "R4 bad checksum");

        // R5 lookup during refill is dropped
        refill_go = 1;
        cycle();
        refill_go = 0;
        r = mk(0);
        lk_req = 1; lk_start = r.s; lk_end = r.e; lk_hash = r.h;
        cycle();
        lk_req = 0;
        chk(lk_valid, 0, "R5 dropped lookup");
        for (int i = 0; i < FILL_N; i++) begin
            r = mk(9 + i);
            fill_vld = 1; fill_start = r.s; fill_end = r.e; fill_hash = r.h;
            cycle();
        end
        fill_vld = 0;
        chk(fill_done, 1, "R6 done pulse");
        cycle();

        // R8 eviction order after hits
        expect_lookup(mk(4), 0, 0, "R8 LRU evicted 4");
        expect_lookup(mk(5), 0, 0, "R8 LRU evicted 5");
        expect_lookup(mk(7), 0, 0, "R8 LRU evicted 7");
        expect_lookup(mk(0), 0, 0, "R8 LRU evicted 0");
        expect_lookup(mk(6), 1, 1, "R8 mismatch hit refreshed");
        expect_lookup(mk(1), 1, 1, "R10 survivor 1");
        expect_lookup(mk(3), 1, 1, "R8 survivor 3");
        for (int i = 9; i < 13; i++) expect_lookup(mk(i), 1, 1, "R8 new records");

        repeat (2) cycle();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule